// File: doc/BRIEF.md
# Delta-Sigma Converter Readout Controller

This block sits on the host side of a slow delta-sigma converter's three-wire serial link. The converter runs in its external-clock, single-cycle mode. On a start request the controller pulls chip select low with the serial clock parked low, so that the converter selects that mode. It then samples the data line at a steady pace, because that line shows the converter's busy flag. Once the flag reads zero, the controller runs 24 clock pulses and captures one bit on each rising edge.

When the frame is complete, the controller splits it into a two-bit header, a sign bit and a 21-bit magnitude. It presents these on a parallel output together with a one-cycle valid strobe. The clock rate is set by a programmable half-period divider. A bound on the number of busy polls turns a stalled converter into an error pulse. A host abort request cuts a frame short by raising chip select, and no result is delivered in that case.

Top module: `dsadc_reader`

## Requirements
- R1: While reset is asserted and right after it is released, csN is 1, sck is 0, busy is 0 and resultValid is 0.
- R2: sck is 0 whenever csN is 1, and sck is 0 in every cycle in which csN falls.
- R3: Before a frame starts, the controller samples sdo once per divider phase with sck held low. It produces no rising sck edge while the converter reports busy (sdo = 1).
- R4: Inside a frame, every high phase of sck, and every low phase between a falling edge and the next rising edge, lasts exactly divHalf+1 system clock cycles.
- R5: A completed frame has exactly 24 rising sck edges. sdo is captured on each rising edge, most significant bit first.
- R6: From a frame whose bits are numbered 23 (first received) down to 0, the outputs are: resultHdr = bits 23:22, resultSign = bit 21, and resultData = bits 20:0.
- R7: resultData, resultSign and resultHdr change only in the cycle in which resultValid is 1. resultValid lasts exactly one cycle for each completed frame.
- R8: If the busy flag is still 1 at the (pollLimit+1)-th sample, timeoutErr pulses for one cycle and csN returns to 1, and no valid strobe is issued. The pulse comes (pollLimit+2)*(divHalf+1) cycles after csN falls.
- R9: abortReq held across a clock edge during the bit-shifting phase raises csN and lowers sck at that edge. No valid strobe follows, and the held result is kept.
- R10: The value on sdo is ignored while csN is 1: no output changes in response to it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts a readout when the controller is idle |
| abortReq | input | 1 | Aborts the frame in progress |
| divHalf | input | DIV_W | sck half-period length minus one, in system clocks |
| pollLimit | input | POLL_W | Busy polls tolerated before the timeout |
| csN | output | 1 | Converter chip select, active low |
| sck | output | 1 | Converter serial clock |
| sdo | input | 1 | Converter serial data / busy flag |
| resultData | output | 21 | Conversion magnitude |
| resultSign | output | 1 | Conversion sign bit |
| resultHdr | output | 2 | Frame header bits (flag and spare) |
| resultValid | output | 1 | One-cycle strobe for a new result |
| timeoutErr | output | 1 | One-cycle strobe for a poll timeout |
| busy | output | 1 | Controller is not idle |

## Verification
The bench sweeps three divider settings, including the one-clock phase where data changes only one edge before it is sampled, and at each setting sends all-zero, all-one, alternating and walking single-bit frames. A framing that is off by one bit, or a sign taken from the wrong position, shows up as a shifted or mis-signed result. The exact cycle of the timeout pulse is measured, which catches a poll counter that stops one poll early or late. A mid-frame abort is followed by a good frame, which exposes a controller that still strobes valid after an abort, or one that fails to recover afterwards.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;
  localparam int FRAME_BITS = 24;
  localparam int HDR_BITS   = 2;
  localparam int RES_W      = FRAME_BITS - HDR_BITS - 1;

  typedef enum logic [2:0] {
    S_IDLE, S_ASSERT_CS, S_POLL_EOC, S_SHIFT, S_DONE, S_ABORT
  } rd_state_t;

  typedef struct packed {
    logic shift;
    logic load;
  } dp_strobe_t;
endpackage

// File: rtl/dsadc_ctrl.sv
module dsadc_ctrl
  import dsadc_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int POLL_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              abortReq,
  input  logic [DIV_W-1:0]  divHalf,
  input  logic [POLL_W-1:0] pollLimit,
  input  logic              sdo,
  output logic              csN,
  output logic              sck,
  output logic              busy,
  output logic              timeoutErr,
  output dp_strobe_t        stb
);
  localparam int CNT_W = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);

  rd_state_t         state;
  logic [DIV_W-1:0]  divCnt;
  logic [POLL_W-1:0] pollCnt;
  logic [CNT_W-1:0]  bitCnt;
  logic              tick;

  assign tick = (divCnt == divHalf);
  assign busy = (state != S_IDLE);

  always_comb begin
    stb.shift = (state == S_SHIFT) && tick && !sck && !abortReq;
    stb.load  = (state == S_DONE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= S_IDLE;
      divCnt     <= '0;
      pollCnt    <= '0;
      bitCnt     <= '0;
      csN        <= 1'b1;
      sck        <= 1'b0;
      timeoutErr <= 1'b0;
    end else begin
      timeoutErr <= 1'b0;
      if (state == S_IDLE || tick) divCnt <= '0;
      else                         divCnt <= divCnt + 1'b1;
      case (state)
        S_IDLE: begin
          if (start) begin
            state   <= S_ASSERT_CS;
            csN     <= 1'b0;
            pollCnt <= '0;
          end
        end
        S_ASSERT_CS: if (tick) state <= S_POLL_EOC;
        S_POLL_EOC: begin
          if (tick) begin
            if (!sdo) begin
              state  <= S_SHIFT;
              bitCnt <= '0;
            end else if (pollCnt == pollLimit) begin
              state      <= S_ABORT;
              csN        <= 1'b1;
              timeoutErr <= 1'b1;
            end else begin
              pollCnt <= pollCnt + 1'b1;
            end
          end
        end
        S_SHIFT: begin
          if (abortReq) begin
            state  <= S_ABORT;
            csN    <= 1'b1;
            sck    <= 1'b0;
            divCnt <= '0;
          end else if (tick) begin
            if (!sck) begin
              sck <= 1'b1;
            end else begin
              sck <= 1'b0;
              if (bitCnt == LAST_BIT) state <= S_DONE;
              else                    bitCnt <= bitCnt + 1'b1;
            end
          end
        end
        S_DONE: begin
          state <= S_IDLE;
          csN   <= 1'b1;
        end
        S_ABORT: if (tick) state <= S_IDLE;
        default: begin
          state <= S_IDLE;
          csN   <= 1'b1;
          sck   <= 1'b0;
        end
      endcase
    end
  end

  p_sck_low_when_deselected_r2: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sck);
  p_cs_fall_sck_low_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |-> !sck);
  p_no_shift_while_busy_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_POLL_EOC && tick && sdo) |=> (state != S_SHIFT));
  p_bit_count_range_r5: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= LAST_BIT);
  p_timeout_releases_cs_r8: assert property (@(posedge clk) disable iff (!rstN)
    timeoutErr |-> csN);
  p_abort_releases_cs_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_SHIFT && abortReq) |=> (csN && !sck));
endmodule

// File: rtl/dsadc_datapath.sv
module dsadc_datapath
  import dsadc_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  dp_strobe_t          stb,
  input  logic                sdo,
  output logic [RES_W-1:0]    resultData,
  output logic                resultSign,
  output logic [HDR_BITS-1:0] resultHdr,
  output logic                resultValid
);
  logic [FRAME_BITS-1:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg    <= '0;
      resultData  <= '0;
      resultSign  <= 1'b0;
      resultHdr   <= '0;
      resultValid <= 1'b0;
    end else begin
      resultValid <= stb.load;
      if (stb.shift) shiftReg <= {shiftReg[FRAME_BITS-2:0], sdo};
      if (stb.load) begin
        resultHdr  <= shiftReg[FRAME_BITS-1 -: HDR_BITS];
        resultSign <= shiftReg[RES_W];
        resultData <= shiftReg[RES_W-1:0];
      end
    end
  end

  p_valid_single_cycle_r7: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);
  p_result_held_r7: assert property (@(posedge clk) disable iff (!rstN)
    !resultValid |-> ($stable(resultData) && $stable(resultSign) && $stable(resultHdr)));
  p_no_load_during_shift_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.load && stb.shift));
endmodule

// File: rtl/dsadc_reader.sv
module dsadc_reader
  import dsadc_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int POLL_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic                abortReq,
  input  logic [DIV_W-1:0]    divHalf,
  input  logic [POLL_W-1:0]   pollLimit,
  output logic                csN,
  output logic                sck,
  input  logic                sdo,
  output logic [RES_W-1:0]    resultData,
  output logic                resultSign,
  output logic [HDR_BITS-1:0] resultHdr,
  output logic                resultValid,
  output logic                timeoutErr,
  output logic                busy
);
  dp_strobe_t stb;

  dsadc_ctrl #(.DIV_W(DIV_W), .POLL_W(POLL_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .abortReq(abortReq),
    .divHalf(divHalf), .pollLimit(pollLimit), .sdo(sdo),
    .csN(csN), .sck(sck), .busy(busy), .timeoutErr(timeoutErr), .stb(stb)
  );

  dsadc_datapath i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .sdo(sdo),
    .resultData(resultData), .resultSign(resultSign),
    .resultHdr(resultHdr), .resultValid(resultValid)
  );

  p_timeout_no_valid_r8: assert property (@(posedge clk) disable iff (!rstN)
    timeoutErr |-> !resultValid);
  p_idle_deselected_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> csN);
endmodule

// File: tb/test_dsadc_reader.sv
`timescale 1ns/1ps
module test_dsadc_reader;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        abortReq = 1'b0;
  logic [7:0]  divHalf = 8'd0;
  logic [15:0] pollLimit = 16'd255;
  logic        csN, sck, sdo;
  logic [20:0] resultData;
  logic        resultSign;
  logic [1:0]  resultHdr;
  logic        resultValid, timeoutErr, busy;

  always #2 clk = ~clk;

  dsadc_reader i_dsadc_reader (
    .clk(clk), .rstN(rstN), .start(start), .abortReq(abortReq),
    .divHalf(divHalf), .pollLimit(pollLimit), .csN(csN), .sck(sck), .sdo(sdo),
    .resultData(resultData), .resultSign(resultSign), .resultHdr(resultHdr),
    .resultValid(resultValid), .timeoutErr(timeoutErr), .busy(busy)
  );

  int vecs = 0;
  int errs = 0;
  bit finished = 1'b0;
  longint cyc = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // converter stub
  logic [21:0] stubWord = 22'd0;
  int          convLen = 10;
  bit          forceBusy = 1'b0;
  logic        stubReady = 1'b0;
  int          convCnt = 10;
  int          idx = 0;
  logic        junk = 1'b0;
  logic        sckS = 1'b0, csS = 1'b1;
  logic [23:0] frameBits;
  assign frameBits = {1'b0, 1'b1, stubWord};
  assign sdo = csN ? junk : ((!stubReady || forceBusy) ? 1'b1 : frameBits[23 - idx]);

  always @(negedge clk) begin
    junk <= ~junk;
    sckS <= sck;
    csS  <= csN;
    if (!rstN) begin
      stubReady <= 1'b0;
      convCnt   <= convLen;
      idx       <= 0;
    end else if (stubReady && !forceBusy) begin
      if (!csS && csN) begin
        stubReady <= 1'b0; convCnt <= convLen; idx <= 0;
      end else if (!csN && sckS && !sck) begin
        if (idx == 23) begin
          stubReady <= 1'b0; convCnt <= convLen; idx <= 0;
        end else idx <= idx + 1;
      end
    end else if (!stubReady) begin
      if (convCnt <= 0) begin stubReady <= 1'b1; idx <= 0; end
      else convCnt <= convCnt - 1;
    end
  end

  // monitor
  int  rises = 0, busyRise = 0, validSeen = 0, runLen = 0, phaseLen = 1;
  bit  inLowRun = 1'b0;
  logic sckM = 1'b0, csM = 1'b1;
  longint tCsFall = 0, tErr = 0;

  always @(negedge clk) begin
    if (rstN) begin
      if (csM && !csN) begin
        rises = 0;
        tCsFall = cyc;
        if (sck) chk(1'b0, "R2 sck high at cs fall", sck, 0);
      end
      if (csN && sck) chk(1'b0, "R2 sck high while deselected", sck, 0);
      if (sck != sckM) begin
        if (!csN) begin
          if (sckM) chk(runLen == phaseLen, "R4 high phase", runLen, phaseLen);
          else if (inLowRun) chk(runLen == phaseLen, "R4 low phase", runLen, phaseLen);
        end
        if (!sckM) begin
          rises++;
          if (!stubReady || forceBusy) busyRise++;
        end
        inLowRun = sckM;
        runLen = 1;
      end else runLen++;
      if (csN) inLowRun = 1'b0;
      if (resultValid) validSeen++;
      if (timeoutErr) tErr = cyc;
    end
    sckM = sck;
    csM = csN;
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic waitIdle();
    int n = 0;
    while (busy && n < 5000) begin step(); n++; end
  endtask

  task automatic runFrame(input logic [21:0] w, input int conv);
    int n = 0;
    int v0;
    waitIdle();
    stubWord = w;
    convLen = conv;
    v0 = validSeen;
    busyRise = 0;
    start = 1'b1; step(); start = 1'b0;
    while (validSeen == v0 && n < 5000) begin step(); n++; end
    chk(validSeen == v0 + 1, "R7 valid strobe after frame", validSeen - v0, 1);
    chk(resultData == w[20:0], "R6 magnitude field", resultData, w[20:0]);
    chk(resultSign == w[21], "R6 sign field", resultSign, w[21]);
    chk(resultHdr == 2'b01, "R6 header field", resultHdr, 2'b01);
    chk(rises == 24, "R5 rising edges per frame", rises, 24);
    chk(busyRise == 0, "R3 no clock while busy", busyRise, 0);
    step();
    chk(!resultValid, "R7 valid one cycle", resultValid, 0);
  endtask

  function automatic logic [21:0] wordFor(input int k);
    logic [31:0] h;
    if (k == 0) return 22'h0;
    if (k == 1) return 22'h3FFFFF;
    if (k == 2) return 22'h2AAAAA;
    if (k == 3) return 22'h155555;
    if (k < 26) return 22'h1 << (k - 4);
    h = 32'h9E3779B9 * k + 32'h7F4A7C15;
    return h[27:6];
  endfunction

  initial begin
    int n;
    int v0;
    logic [20:0] held;
    repeat (4) step();
    // R1 reset values
    chk(csN == 1'b1, "R1 csN in reset", csN, 1);
    chk(sck == 1'b0, "R1 sck in reset", sck, 0);
    chk(resultValid == 1'b0, "R1 valid in reset", resultValid, 0);
    rstN = 1'b1;
    step();
    chk(csN == 1'b1 && sck == 1'b0 && !busy && !resultValid, "R1 after reset",
        {csN, sck, busy, resultValid}, 4'b1000);

    // R10 sdo toggles while deselected: nothing moves
    v0 = validSeen;
    held = resultData;
    repeat (40) step();
    chk(csN == 1'b1, "R10 csN stays high", csN, 1);
    chk(validSeen == v0, "R10 no valid from idle sdo", validSeen - v0, 0);
    chk(resultData == held, "R10 result unchanged", resultData, held);

    // main sweep
    for (int d = 0; d < 3; d++) begin
      divHalf = 8'(d);
      phaseLen = d + 1;
      for (int k = 0; k < 30; k++) runFrame(wordFor(k), (k * 13) % 37 + 1);
    end

    // R8 timeout
    waitIdle();
    divHalf = 8'd1; phaseLen = 2;
    pollLimit = 16'd3;
    forceBusy = 1'b1;
    v0 = validSeen;
    tErr = 0;
    start = 1'b1; step(); start = 1'b0;
    n = 0;
    while (tErr == 0 && n < 200) begin step(); n++; end
    chk(tErr - tCsFall == 10, "R8 timeout cycle", tErr - tCsFall, 10);
    chk(csN == 1'b1, "R8 csN released", csN, 1);
    repeat (10) step();
    chk(validSeen == v0, "R8 no valid on timeout", validSeen - v0, 0);
    forceBusy = 1'b0;
    pollLimit = 16'd255;
    runFrame(22'h2C0FFE, 5);

    // R9 abort
    waitIdle();
    held = resultData;
    convLen = 20;
    v0 = validSeen;
    stubWord = 22'h12345;
    start = 1'b1; step(); start = 1'b0;
    n = 0;
    while (rises < 5 && n < 2000) begin step(); n++; end
    abortReq = 1'b1; step(); abortReq = 1'b0;
    chk(csN == 1'b1 && sck == 1'b0, "R9 abort releases bus", {csN, sck}, 2'b10);
    repeat (60) step();
    chk(validSeen == v0, "R9 no valid after abort", validSeen - v0, 0);
    chk(resultData == held, "R9 result kept after abort", resultData, held);
    runFrame(22'h3A5A5A, 7);

    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    wait (cyc > 150000);
    if (!finished) begin
      finished = 1'b1;
      chk(1'b0, "watchdog expired", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule